// File: doc/BRIEF.md
# Keyed Watchdog Timer with Standby Wakeup

This block is an 8-bit up-counter that works as a watchdog or as an interval timer. It is clocked through a free-running prescaler, and a 3-bit select picks one of eight tick rates. Software reaches the counter and the control register through a single 16-bit write port. A write lands only when the upper byte carries the key byte for the register being addressed. A write with any other key is dropped. Reads return the 8-bit value with the upper byte as zero.

The block also controls the exit from standby. A sleep request moves the block into a standby wait, and the counter holds its value there. A rising edge on the NMI input starts the count. When the counter wraps, the block pulses a clock-resume request and leaves the overflow flag alone. It then keeps counting up from 0x00. If the standby-select input is still high when the count reaches 0x80, the block pulses a standby-entry request and returns to the wait. If that input goes low first, the block returns to normal operation and the wakeup count stops.

A four-state machine does the sequencing:
- ST_RUN is normal operation.
- ST_STBY_IDLE holds the counter until the NMI edge.
- ST_STBY_CNT counts toward the wakeup wrap.
- ST_WAKE counts toward 0x80.

The transitions are:
- T_SLEEP goes from ST_RUN to ST_STBY_IDLE on a sleep request.
- T_NMI goes from ST_STBY_IDLE to ST_STBY_CNT on an NMI rising edge.
- T_WRAP goes from ST_STBY_CNT to ST_WAKE on a wrap.
- T_DROP goes from ST_WAKE to ST_RUN when standby-select is low.
- T_REARM goes from ST_WAKE to ST_STBY_IDLE when the count reaches 0x80.

Top module: `wdog_standby_top`

## Requirements
- R1: A write with `wr_sel`=0 whose bits 15:8 equal 0x5A loads bits 7:0 into the counter; reading with `rd_sel`=0 returns `{8'h00, counter}`.
- R2: A write with `wr_sel`=1 whose bits 15:8 equal 0xA5 loads the control fields: enable at bit 7, reset-mode at bit 6, clock select at bits 2:0. Reading with `rd_sel`=1 returns these fields at the same positions, with the overflow flag at bit 5 and zeros elsewhere.
- R3: A write whose key byte does not match the addressed register changes no register state.
- R4: Select codes 0 to 7 advance the counter once every 1, 4, 16, 32, 64, 256, 1024 or 4096 clocks respectively.
- R5: In ST_RUN with enable=1, a step from 0xFF takes the counter to 0x00, sets the overflow flag and gives a one-cycle pulse. The pulse is on `rst_req` when reset-mode=1 and on `irq_req` when reset-mode=0, in the same cycle as the wrap.
- R6: In ST_RUN with enable=0, the counter holds and neither `rst_req` nor `irq_req` is raised.
- R7: A keyed control write with bit 5 = 0 clears the overflow flag; writing 1 to bit 5 leaves the flag unchanged.
- R8: `sleep_req` in ST_RUN enters standby wait, where the counter holds until a rising edge on `nmi`. After that edge it counts on every tick regardless of the enable bit.
- R9: The standby wrap gives a one-cycle `clk_resume` pulse with the counter at 0x00. It does not set the overflow flag and raises neither `rst_req` nor `irq_req`. Counting continues from 0x00.
- R10: If `stby_sel` is 1 when the wakeup count reaches 0x80, a one-cycle `stby_req` pulse is given and the counter holds at 0x80 until the next NMI rising edge.
- R11: If `stby_sel` is 0 during the wakeup count, the block returns to ST_RUN. The count stops while enable=0 and resumes normal counting once enable is set.
- R12: After reset every register reads 0 and all four request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 control |
| wr_data | input | 16 | Key byte in 15:8, value in 7:0 |
| rd_sel | input | 1 | Read target: 0 counter, 1 control |
| rd_data | output | 16 | Read value, upper byte zero |
| sleep_req | input | 1 | Request to enter standby wait |
| nmi | input | 1 | NMI line; a rising edge starts the wakeup count |
| stby_sel | input | 1 | Standby-select level |
| rst_req | output | 1 | Watchdog reset request pulse |
| irq_req | output | 1 | Interval interrupt pulse |
| clk_resume | output | 1 | Clock-restart request pulse |
| stby_req | output | 1 | Standby re-entry request pulse |

## Verification
The bench sends a wrong key and also the other register's key to each register. A design that checked only one key, or checked the wrong one, would let a stray write load the counter or disable the timer. It measures the exact interval between counter steps for several select codes, including the slowest. A wrong prescaler tap would show up as a wrong period even when counting still looks plausible. It drives the standby path through two complete wake cycles. The checks are that the counter freezes before the NMI edge, that the wrap raises only `clk_resume` with the flag left clear, and that the re-entry pulse lands exactly at 0x80. A design that flagged the standby wrap, counted before the edge, or stopped one step early or late fails these. The bench also confirms that lowering `stby_sel` freezes the count instead of re-entering standby, and that the overflow flag cannot be set by a write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W   = 8;
    localparam int BUS_W   = 16;
    localparam int CKS_W   = 3;
    localparam int N_TAPS  = 1 << CKS_W;

    localparam int BIT_EN   = 7;
    localparam int BIT_MODE = 6;
    localparam int BIT_OVF  = 5;

    localparam logic [CNT_W-1:0] KEY_COUNT = 8'h5A;
    localparam logic [CNT_W-1:0] KEY_CTRL  = 8'hA5;
    localparam logic [CNT_W-1:0] REARM_AT  = 8'h80;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_STBY_IDLE = 2'd1,
        ST_STBY_CNT  = 2'd2,
        ST_WAKE      = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic             en;
        logic             rst_mode;
        logic             ovf;
        logic [CKS_W-1:0] cks;
    } ctrl_t;

    // log2 of the prescaler division for each select code
    function automatic int tap_shift(input int code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            5:       return 8;
            6:       return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
    import wdog_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);

    logic [PRE_W-1:0]  pre_q;
    logic [N_TAPS-1:0] tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // each tap fires once every 2**shift clocks
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        if (SH == 0) begin : g_every
            assign tap[g] = 1'b1;
        end else begin : g_div
            assign tap[g] = &pre_q[SH-1:0];
        end
    end

    assign tick = tap[cks];

endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             ovf_set,
    output ctrl_t            ctrl,
    output logic             cnt_wr,
    output logic [CNT_W-1:0] cnt_wdata
);

    logic [CNT_W-1:0] key;
    logic [CNT_W-1:0] val;
    logic             ctrl_wr;
    logic             spare_unused;

    assign key          = wr_data[BUS_W-1:CNT_W];
    assign val          = wr_data[CNT_W-1:0];
    assign spare_unused = ^val[4:3];

    assign cnt_wr    = wr_en && !wr_sel && (key == KEY_COUNT);
    assign ctrl_wr   = wr_en &&  wr_sel && (key == KEY_CTRL);
    assign cnt_wdata = val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.en       <= val[BIT_EN];
                ctrl.rst_mode <= val[BIT_MODE];
                ctrl.cks      <= val[CKS_W-1:0];
            end
            if (ovf_set)      ctrl.ovf <= 1'b1;
            else if (ctrl_wr) ctrl.ovf <= ctrl.ovf & val[BIT_OVF];
        end
    end

    // R3: a control write without the control key leaves the fields alone
    p_key_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_sel && key == KEY_CTRL))
        |=> $stable({ctrl.en, ctrl.rst_mode, ctrl.cks}));

    // R7: the flag can only rise through an overflow, never through a write
    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.ovf) |-> $past(ovf_set));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             rst_mode,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             sleep_req,
    input  logic             nmi,
    input  logic             stby_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_set,
    output logic             rst_req,
    output logic             irq_req,
    output logic             clk_resume,
    output logic             stby_req
);

    wd_state_e state, state_nx;
    logic      nmi_q, nmi_rise;
    logic      count_en, step, wrap, reach_rearm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi;
    end
    assign nmi_rise = nmi & ~nmi_q;

    always_comb begin
        unique case (state)
            ST_RUN:       count_en = en;
            ST_STBY_IDLE: count_en = 1'b0;
            ST_STBY_CNT:  count_en = 1'b1;
            ST_WAKE:      count_en = stby_sel;
            default:      count_en = 1'b0;
        endcase
    end

    assign step        = count_en && tick && !cnt_wr;
    assign wrap        = step && (cnt == '1);
    assign reach_rearm = step && (state == ST_WAKE) && (cnt == REARM_AT - 1'b1);
    assign ovf_set     = wrap && (state == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // transitions T_SLEEP, T_NMI, T_WRAP, T_DROP, T_REARM
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:       if (sleep_req)   state_nx = ST_STBY_IDLE;
            ST_STBY_IDLE: if (nmi_rise)    state_nx = ST_STBY_CNT;
            ST_STBY_CNT:  if (wrap)        state_nx = ST_WAKE;
            ST_WAKE: begin
                if (!stby_sel)             state_nx = ST_RUN;
                else if (reach_rearm)      state_nx = ST_STBY_IDLE;
            end
            default:                       state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= cnt_wdata;
        else if (step)   cnt <= cnt + 1'b1;
    end

    // outputs: one-cycle registered pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req    <= 1'b0;
            irq_req    <= 1'b0;
            clk_resume <= 1'b0;
            stby_req   <= 1'b0;
        end else begin
            rst_req    <= ovf_set &&  rst_mode;
            irq_req    <= ovf_set && !rst_mode;
            clk_resume <= wrap && (state == ST_STBY_CNT);
            stby_req   <= reach_rearm;
        end
    end

    // R5: a watchdog or interval pulse lands together with the wrap to zero
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || irq_req) |-> (cnt == '0));

    // R5: at most one request pulse per cycle
    p_one_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req, irq_req, clk_resume, stby_req}));

    // R6: disabled timer in normal mode keeps the count and stays silent
    p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !en && !cnt_wr) |=> ($stable(cnt) && !rst_req && !irq_req));

    // R8: standby wait freezes the counter
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY_IDLE && !cnt_wr) |=> $stable(cnt));

    // R9: clock resume coincides with a zero count and the wake phase
    p_resume_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_resume |-> (cnt == '0 && state == ST_WAKE));

    // R10: re-entry pulse only at the rearm count, back in standby wait
    p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stby_req |-> (cnt == REARM_AT && state == ST_STBY_IDLE));

endmodule

// File: rtl/wdog_standby_top.sv
module wdog_standby_top
    import wdog_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    input  logic        rd_sel,
    output logic [15:0] rd_data,
    input  logic        sleep_req,
    input  logic        nmi,
    input  logic        stby_sel,
    output logic        rst_req,
    output logic        irq_req,
    output logic        clk_resume,
    output logic        stby_req
);

    ctrl_t            ctrl;
    logic             tick, cnt_wr, ovf_set;
    logic [CNT_W-1:0] cnt_wdata, cnt, ctrl_byte;

    wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .cks   (ctrl.cks),
        .tick  (tick)
    );

    wdog_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ovf_set   (ovf_set),
        .ctrl      (ctrl),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata)
    );

    wdog_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .en         (ctrl.en),
        .rst_mode   (ctrl.rst_mode),
        .cnt_wr     (cnt_wr),
        .cnt_wdata  (cnt_wdata),
        .sleep_req  (sleep_req),
        .nmi        (nmi),
        .stby_sel   (stby_sel),
        .cnt        (cnt),
        .ovf_set    (ovf_set),
        .rst_req    (rst_req),
        .irq_req    (irq_req),
        .clk_resume (clk_resume),
        .stby_req   (stby_req)
    );

    assign ctrl_byte = {ctrl.en, ctrl.rst_mode, ctrl.ovf, 2'b00, ctrl.cks};
    assign rd_data   = {8'h00, rd_sel ? ctrl_byte : cnt};

    // R9: the standby wrap leaves the overflow flag untouched
    p_quiet_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_resume |-> $stable(ctrl.ovf));

endmodule

// File: tb/tb_wdog_standby_top.sv
`timescale 1ns/1ps
module tb_wdog_standby_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        sleep_req = 1'b0, nmi = 1'b0, stby_sel = 1'b0;
    logic        rst_req, irq_req, clk_resume, stby_req;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    wdog_standby_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .sleep_req(sleep_req), .nmi(nmi), .stby_sel(stby_sel),
        .rst_req(rst_req), .irq_req(irq_req), .clk_resume(clk_resume),
        .stby_req(stby_req)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] key, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = {key, val};
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] v);
        rd_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // cycles between two successive counter changes
    task automatic measure(output int period);
        logic [15:0] a, b;
        int k;
        rd(1'b0, a);
        do begin @(negedge clk); rd(1'b0, b); end while (b == a);
        a = b; k = 0;
        do begin @(negedge clk); k++; rd(1'b0, b); end while (b == a && k < 5000);
        period = k;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(1'b0, v); check("R12 counter after reset", v, 0);
        rd(1'b1, v); check("R12 control after reset", v, 0);
        check("R12 outputs after reset", {rst_req, irq_req, clk_resume, stby_req}, 0);
    endtask

    task automatic t_keys();
        logic [15:0] v;
        wr(1'b0, 8'h5A, 8'h3C);
        rd(1'b0, v); check("R1 keyed counter load", v, 16'h003C);
        wr(1'b1, 8'hA5, 8'h06);
        rd(1'b1, v); check("R2 keyed control load", v, 16'h0006);
        wr(1'b0, 8'h5B, 8'h11);
        rd(1'b0, v); check("R3 bad counter key", v, 16'h003C);
        wr(1'b0, 8'hA5, 8'h22);
        rd(1'b0, v); check("R3 control key on counter", v, 16'h003C);
        wr(1'b1, 8'h5A, 8'hC1);
        rd(1'b1, v); check("R3 counter key on control", v, 16'h0006);
        wr(1'b1, 8'h00, 8'hFF);
        rd(1'b1, v); check("R3 zero key on control", v, 16'h0006);
        wr(1'b1, 8'hA5, 8'h00);
    endtask

    task automatic t_off();
        logic [15:0] v;
        logic seen;
        wr(1'b0, 8'h5A, 8'hFF);
        seen = 1'b0;
        repeat (20) begin @(negedge clk); seen |= rst_req | irq_req; end
        rd(1'b0, v); check("R6 disabled counter holds", v, 16'h00FF);
        check("R6 no request while disabled", seen, 0);
    endtask

    task automatic t_prescale();
        int p;
        wr(1'b1, 8'hA5, 8'h80); measure(p); check("R4 code 0 period", p, 1);
        wr(1'b1, 8'hA5, 8'h82); measure(p); check("R4 code 2 period", p, 16);
        wr(1'b1, 8'hA5, 8'h84); measure(p); check("R4 code 4 period", p, 64);
        wr(1'b1, 8'hA5, 8'h87); measure(p); check("R4 code 7 period", p, 4096);
        wr(1'b1, 8'hA5, 8'h00);
    endtask

    task automatic t_overflow(input logic rmode);
        logic [15:0] v;
        int k;
        wr(1'b0, 8'h5A, 8'hFC);
        wr(1'b1, 8'hA5, {1'b1, rmode, 6'b0});
        k = 0;
        do begin @(negedge clk); k++; end while (!(rst_req | irq_req) && k < 20);
        check("R5 cycles to wrap", k, 4);
        check("R5 reset pulse", rst_req, rmode);
        check("R5 interrupt pulse", irq_req, !rmode);
        rd(1'b0, v); check("R5 counter wrapped", v, 0);
        rd(1'b1, v); check("R5 flag set", v[5], 1);
        @(negedge clk);
        check("R5 pulse width", rst_req | irq_req, 0);
        wr(1'b1, 8'hA5, 8'h20);
        rd(1'b1, v); check("R7 writing 1 keeps flag", v, 16'h0020);
        wr(1'b1, 8'hA5, 8'h00);
        rd(1'b1, v); check("R7 writing 0 clears flag", v, 16'h0000);
    endtask

    task automatic t_standby();
        logic [15:0] v;
        logic bad;
        int k;
        wr(1'b1, 8'hA5, 8'h00);
        wr(1'b0, 8'h5A, 8'hFE);
        stby_sel = 1'b1;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        repeat (6) @(negedge clk);
        rd(1'b0, v); check("R8 counter frozen before NMI", v, 16'h00FE);
        nmi = 1'b1;
        k = 0; bad = 1'b0;
        do begin @(negedge clk); k++; bad |= rst_req | irq_req; end
        while (!clk_resume && k < 20);
        check("R8 NMI starts count, cycles to wrap", k, 3);
        rd(1'b0, v); check("R9 counter zero at resume", v, 0);
        rd(1'b1, v); check("R9 flag not set", v[5], 0);
        check("R9 no reset or interrupt", bad, 0);
        nmi = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (!stby_req && k < 300);
        check("R10 steps to rearm", k, 128);
        rd(1'b0, v); check("R10 count at rearm", v, 16'h0080);
        repeat (8) @(negedge clk);
        rd(1'b0, v); check("R10 holds after rearm", v, 16'h0080);
        nmi = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!clk_resume && k < 300);
        check("R9 second wake cycles", k, 129);
        stby_sel = 1'b0; nmi = 1'b0;
        bad = 1'b0;
        repeat (200) begin @(negedge clk); bad |= stby_req; end
        rd(1'b0, v); check("R11 count stopped", v, 0);
        check("R11 no re-entry", bad, 0);
        wr(1'b1, 8'hA5, 8'h80);
        repeat (3) @(negedge clk);
        rd(1'b0, v); check("R11 normal counting resumes", v != 0, 1);
        wr(1'b1, 8'hA5, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_keys();
        t_off();
        t_prescale();
        t_overflow(1'b1);
        t_overflow(1'b0);
        t_standby();
        finish_run();
    end

endmodule